// File: doc/BRIEF.md
# Keyed Module Run-State Controller

This block keeps a two-bit run-state request for each of a set of peripheral modules and tracks the state each module has actually reached. Software programs the requests through a 32-bit register bus. Sixteen modules are packed into each request word. A matching bank of status words reports the reached states. A status field follows its request only after a fixed per-step latency, and it walks through legal intermediate states on the way.

Request writes are refused unless a protection register has been opened with a key. Writing a second key closes it again. Driver code normally opens the lock, rewrites a request word, closes the lock, and then polls until the status word equals the request word.

Each module gets a reset output and a clock-enable output. Both are decoded from the module's reached state, not from its request.

Top module: `modstate_ctrl`

## Requirements
- R1: After system reset, every request field and every status field holds code 1, the protection register reads 0 (locked), every module reset output is 1, and every clock enable is 0.
- R2: State codes are standby=0, reset=1, stop=2 and run=3. Module n occupies bits [2*(n%16)+1 : 2*(n%16)] of word n/16. Request word k is at offset 0x900+4k and status word k is at 0x960+4k, and both use the same layout.
- R3: Writing 0xA5A5A501 to offset 0xCF4 opens the lock and writing 0xA5A5A500 closes it. Any other value written there leaves the lock unchanged. Reading 0xCF4 returns 1 in bit 0 while the lock is open and 0 in every other bit.
- R4: A request-word write made while the lock is closed is ignored. The request word keeps its value, and no status or output changes.
- R5: Each state step lands in the status field exactly LATENCY clock edges after the request write. Once status equals request, status holds still.
- R6: When a stopped module is asked for reset, it passes through standby (one step) before it reaches reset (a second step).
- R7: When a running or standby module is asked for reset, it reaches reset in a single step.
- R8: When a standby module is asked for run, it passes through reset before it reaches run.
- R9: When a stopped or reset module is asked for run, it reaches run in a single step.
- R10: Requests for standby or stop are reached in a single step from any other state.
- R11: A module's reset output is 1 in standby and reset and 0 otherwise. Its clock enable is 1 only in run.
- R12: Reads of unmapped offsets return 0. Writes to status words have no effect.
- R13: If a request is rewritten on the same edge that a step lands, the step still lands toward the old request. The next step, toward the new request, lands LATENCY edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mod_rst_o | output | N_MOD | Per-module reset, high in standby or reset |
| mod_clk_en_o | output | N_MOD | Per-module clock enable, high in run |

## Verification
A request write and the completion of a pending step can land on the same clock edge. In that case the step must finish toward the request that was in force before the edge, and the latency count must restart for the new request. The bench provokes this by writing run to a module, then writing reset on exactly the LATENCY-th edge after the first write. It expects run to appear on that edge and reset to appear LATENCY edges later. Exact-edge sampling of multi-step paths also shows whether an intermediate state was skipped or an illegal one was shown.

// File: rtl/msc_pkg.sv
package msc_pkg;

    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_RESET   = 2'd1,
        ST_STOP    = 2'd2,
        ST_RUN     = 2'd3
    } mstate_e;

    localparam logic [31:0] KEY_OPEN = 32'hA5A5_A501;
    localparam logic [31:0] KEY_SHUT = 32'hA5A5_A500;

    // One legal step from cur toward goal (only called when they differ)
    function automatic mstate_e step_toward(input mstate_e cur, input mstate_e goal);
        mstate_e nxt;
        unique case (goal)
            ST_RESET: nxt = (cur == ST_STOP)    ? ST_STANDBY : ST_RESET;
            ST_RUN:   nxt = (cur == ST_STANDBY) ? ST_RESET   : ST_RUN;
            default:  nxt = goal;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/msc_keylock.sv
module msc_keylock #(
    parameter logic [31:0] OPEN_KEY = 32'hA5A5_A501,
    parameter logic [31:0] SHUT_KEY = 32'hA5A5_A500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hit_i,
    input  logic [31:0] wdata_i,
    output logic        open_o
);

    typedef struct packed {
        logic open;
    } kl_t;

    kl_t kl_d, kl_q;

    always_comb begin
        kl_d = kl_q;
        if (hit_i) begin
            if (wdata_i == OPEN_KEY) begin
                kl_d.open = 1'b1;
            end else if (wdata_i == SHUT_KEY) begin
                kl_d.open = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kl_q <= '0;
        end else begin
            kl_q <= kl_d;
        end
    end

    assign open_o = kl_q.open;

endmodule

// File: rtl/msc_reqfile.sv
module msc_reqfile #(
    parameter  int N_MOD   = 32,
    localparam int N_WORDS = (N_MOD + 15) / 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_WORDS-1:0]   wr_hit_i,
    input  logic [31:0]          wdata_i,
    input  logic                 unlocked_i,
    output logic [2*N_MOD-1:0]   req_o,
    output logic [N_MOD-1:0]     chg_o
);

    typedef struct packed {
        logic [2*N_MOD-1:0] fld;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        for (int m = 0; m < N_MOD; m++) begin
            if (unlocked_i && wr_hit_i[m / 16]) begin
                rf_d.fld[2*m +: 2] = wdata_i[2*(m % 16) +: 2];
            end
        end
        for (int m = 0; m < N_MOD; m++) begin
            chg_o[m] = (rf_d.fld[2*m +: 2] != rf_q.fld[2*m +: 2]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q.fld <= {N_MOD{2'b01}};
        end else begin
            rf_q <= rf_d;
        end
    end

    assign req_o = rf_q.fld;

endmodule

// File: rtl/msc_mod_seq.sv
module msc_mod_seq
    import msc_pkg::*;
#(
    parameter  int LATENCY = 4,
    localparam int CW      = $clog2(LATENCY + 1)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  mstate_e goal_i,
    input  logic    restart_i,
    output mstate_e state_o,
    output logic    rst_o,
    output logic    clk_en_o
);

    typedef struct packed {
        mstate_e       st;
        logic [CW-1:0] cnt;
    } sq_t;

    sq_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        if (sq_q.st != goal_i) begin
            if (sq_q.cnt == CW'(LATENCY - 1)) begin
                sq_d.st  = step_toward(sq_q.st, goal_i);
                sq_d.cnt = '0;
            end else begin
                sq_d.cnt = sq_q.cnt + 1'b1;
            end
        end else begin
            sq_d.cnt = '0;
        end
        // a new request restarts the latency window
        if (restart_i) begin
            sq_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q.st  <= ST_RESET;
            sq_q.cnt <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign state_o  = sq_q.st;
    assign rst_o    = (sq_q.st == ST_STANDBY) || (sq_q.st == ST_RESET);
    assign clk_en_o = (sq_q.st == ST_RUN);

endmodule

// File: rtl/modstate_ctrl.sv
module modstate_ctrl
    import msc_pkg::*;
#(
    parameter int N_MOD     = 32,
    parameter int LATENCY   = 4,
    parameter int ADDR_W    = 12,
    parameter int REQ_BASE  = 'h900,
    parameter int STAT_BASE = 'h960,
    parameter int PROT_ADDR = 'hCF4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [N_MOD-1:0]  mod_rst_o,
    output logic [N_MOD-1:0]  mod_clk_en_o
);

    localparam int N_WORDS = (N_MOD + 15) / 16;
    localparam int PADW    = N_WORDS * 32;

    logic [N_WORDS-1:0] req_hit;
    logic [N_WORDS-1:0] stat_hit;
    logic               prot_hit;
    logic               unlocked;
    logic [2*N_MOD-1:0] req_flat;
    logic [2*N_MOD-1:0] stat_flat;
    logic [N_MOD-1:0]   req_chg;
    logic [PADW-1:0]    req_pad;
    logic [PADW-1:0]    stat_pad;

    always_comb begin
        for (int w = 0; w < N_WORDS; w++) begin
            req_hit[w]  = (bus_addr == ADDR_W'(REQ_BASE + 4 * w));
            stat_hit[w] = (bus_addr == ADDR_W'(STAT_BASE + 4 * w));
        end
        prot_hit = (bus_addr == ADDR_W'(PROT_ADDR));
    end

    msc_keylock #(
        .OPEN_KEY (KEY_OPEN),
        .SHUT_KEY (KEY_SHUT)
    ) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (bus_wen && prot_hit),
        .wdata_i (bus_wdata),
        .open_o  (unlocked)
    );

    msc_reqfile #(
        .N_MOD (N_MOD)
    ) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit_i   ({N_WORDS{bus_wen}} & req_hit),
        .wdata_i    (bus_wdata),
        .unlocked_i (unlocked),
        .req_o      (req_flat),
        .chg_o      (req_chg)
    );

    for (genvar m = 0; m < N_MOD; m++) begin : g_mod
        mstate_e st;

        msc_mod_seq #(
            .LATENCY (LATENCY)
        ) u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .goal_i    (mstate_e'(req_flat[2*m +: 2])),
            .restart_i (req_chg[m]),
            .state_o   (st),
            .rst_o     (mod_rst_o[m]),
            .clk_en_o  (mod_clk_en_o[m])
        );

        assign stat_flat[2*m +: 2] = st;
    end

    assign req_pad  = PADW'(req_flat);
    assign stat_pad = PADW'(stat_flat);

    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < N_WORDS; w++) begin
            if (req_hit[w]) begin
                bus_rdata = req_pad[w*32 +: 32];
            end
            if (stat_hit[w]) begin
                bus_rdata = stat_pad[w*32 +: 32];
            end
        end
        if (prot_hit) begin
            bus_rdata = {31'b0, unlocked};
        end
    end

endmodule

// File: rtl/modstate_ctrl_chk.sv
module modstate_ctrl_chk #(
    parameter int N_MOD     = 32,
    parameter int ADDR_W    = 12,
    parameter int PROT_ADDR = 'hCF4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wen,
    input logic [31:0]        bus_wdata,
    input logic               unlocked,
    input logic [2*N_MOD-1:0] req_flat,
    input logic [2*N_MOD-1:0] stat_flat,
    input logic [N_MOD-1:0]   mod_rst,
    input logic [N_MOD-1:0]   mod_clk_en
);

    AST_LOCK_FREEZES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(req_flat)); // R4

    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == ADDR_W'(PROT_ADDR) && bus_wdata == 32'hA5A5_A501)
        |=> unlocked); // R3

    AST_KEY_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == ADDR_W'(PROT_ADDR) && bus_wdata == 32'hA5A5_A500)
        |=> !unlocked); // R3

    AST_SETTLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_flat == req_flat) |=> $stable(stat_flat)); // R5

    for (genvar m = 0; m < N_MOD; m++) begin : g_chk
        AST_STOP_SKIPS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_flat[2*m +: 2] == 2'd2) |=> (stat_flat[2*m +: 2] != 2'd1)); // R6

        AST_STANDBY_SKIPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_flat[2*m +: 2] == 2'd0) |=> (stat_flat[2*m +: 2] != 2'd3)); // R8

        AST_RST_CLK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
            !(mod_rst[m] && mod_clk_en[m])); // R11
    end

endmodule

bind modstate_ctrl modstate_ctrl_chk #(
    .N_MOD     (N_MOD),
    .ADDR_W    (ADDR_W),
    .PROT_ADDR (PROT_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wen    (bus_wen),
    .bus_wdata  (bus_wdata),
    .unlocked   (unlocked),
    .req_flat   (req_flat),
    .stat_flat  (stat_flat),
    .mod_rst    (mod_rst_o),
    .mod_clk_en (mod_clk_en_o)
);

// File: tb/tb_modstate_ctrl.sv
module tb_modstate_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N_MOD      = 32;
    localparam int LAT        = 4;

    // {module, start, target, mid, final, req}
    localparam int VEC [9][6] = '{
        '{ 3, 1, 3, 3, 3,  9},  // R9 reset -> run
        '{ 3, 3, 1, 1, 1,  7},  // R7 run -> reset
        '{ 3, 1, 2, 2, 2, 10},  // R10 reset -> stop
        '{ 3, 2, 1, 0, 1,  6},  // R6 stop -> standby -> reset
        '{20, 1, 0, 0, 0, 10},  // R10 reset -> standby
        '{20, 0, 3, 1, 3,  8},  // R8 standby -> reset -> run
        '{20, 3, 2, 2, 2, 10},  // R10 run -> stop
        '{20, 2, 3, 3, 3,  9},  // R9 stop -> run
        '{16, 0, 1, 1, 1,  7}   // R7 standby -> reset
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic              bus_wen = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [N_MOD-1:0]  mod_rst_o;
    logic [N_MOD-1:0]  mod_clk_en_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] req_sh [2];

    always #(CLK_PERIOD / 2) clk = ~clk;

    modstate_ctrl #(.N_MOD(N_MOD), .LATENCY(LAT)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wen      (bus_wen),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .mod_rst_o    (mod_rst_o),
        .mod_clk_en_o (mod_clk_en_o)
    );

    task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wen = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wen = 1'b0; bus_addr = 12'h000;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
        bus_addr = 12'h000;
    endtask

    task automatic set_field(input int m, input int code);
        req_sh[m / 16][2*(m % 16) +: 2] = 2'(code);
        bus_write(12'(12'h900 + 4 * (m / 16)), req_sh[m / 16]);
    endtask

    task automatic stat_field(input int m, output logic [31:0] f);
        logic [31:0] w;
        bus_read(12'(12'h960 + 4 * (m / 16)), w);
        f = 32'(w[2*(m % 16) +: 2]);
    endtask

    task automatic settle(input int m);
        logic [31:0] rw, sw;
        for (int k = 0; k < 50; k++) begin
            bus_read(12'(12'h900 + 4 * (m / 16)), rw);
            bus_read(12'(12'h960 + 4 * (m / 16)), sw);
            if (rw == sw) break;
            @(posedge clk);
            @(negedge clk);
        end
        check("R5", "settle status==request", sw, rw);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R5 watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, f;
        req_sh[0] = 32'h5555_5555;
        req_sh[1] = 32'h5555_5555;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(12'h900, v); check("R1", "req word0", v, 32'h5555_5555);
        bus_read(12'h904, v); check("R1", "req word1", v, 32'h5555_5555);
        bus_read(12'h960, v); check("R1", "stat word0", v, 32'h5555_5555);
        bus_read(12'h964, v); check("R1", "stat word1", v, 32'h5555_5555);
        bus_read(12'hCF4, v); check("R1", "lock closed", v, 32'h0);
        check("R1", "mod_rst", mod_rst_o, 32'hFFFF_FFFF);
        check("R1", "clk_en", mod_clk_en_o, 32'h0);

        // R4 locked write ignored
        bus_write(12'h900, 32'hFFFF_FFFF);
        bus_read(12'h900, v); check("R4", "locked req write", v, 32'h5555_5555);
        repeat (2 * LAT + 2) @(posedge clk);
        @(negedge clk);
        bus_read(12'h960, v); check("R4", "status untouched", v, 32'h5555_5555);
        check("R4", "clk_en untouched", mod_clk_en_o, 32'h0);

        // R3 key handling
        bus_write(12'hCF4, 32'hA5A5_A501);
        bus_read(12'hCF4, v); check("R3", "open key", v, 32'h1);
        bus_write(12'hCF4, 32'hA5A5_A502);
        bus_read(12'hCF4, v); check("R3", "other value keeps open", v, 32'h1);

        // vector table
        for (int i = 0; i < 9; i++) begin
            automatic int m = VEC[i][0];
            automatic string rq = $sformatf("R%0d", VEC[i][5]);
            set_field(m, VEC[i][1]);
            settle(m);
            set_field(m, VEC[i][2]);
            repeat (LAT - 1) @(posedge clk);
            @(negedge clk);
            stat_field(m, f); check("R5", "before latency", f, 32'(VEC[i][1]));
            @(posedge clk);
            @(negedge clk);
            stat_field(m, f); check(rq, "first step", f, 32'(VEC[i][3]));
            repeat (LAT) @(posedge clk);
            @(negedge clk);
            stat_field(m, f); check(rq, "second step", f, 32'(VEC[i][4]));
            bus_read(12'(12'h960 + 4 * (m / 16)), v);
            check("R2", "status word layout", v, req_sh[m / 16]);
            check("R11", "reset output", 32'(mod_rst_o[m]), 32'(VEC[i][4] <= 1));
            check("R11", "clock enable", 32'(mod_clk_en_o[m]), 32'(VEC[i][4] == 3));
        end
        bus_read(12'h960, v); check("R2", "word0 final", v, req_sh[0]);

        // R13 request rewrite on the step-landing edge
        set_field(5, 1);
        settle(5);
        set_field(5, 3);
        repeat (LAT - 1) @(posedge clk);
        set_field(5, 1);
        stat_field(5, f); check("R13", "old step lands", f, 32'd3);
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk);
        stat_field(5, f); check("R13", "new step not early", f, 32'd3);
        @(posedge clk);
        @(negedge clk);
        stat_field(5, f); check("R13", "new step lands", f, 32'd1);

        // R12 unmapped reads and status writes
        bus_read(12'h908, v); check("R12", "unmapped 0x908", v, 32'h0);
        bus_read(12'h95C, v); check("R12", "unmapped 0x95C", v, 32'h0);
        bus_read(12'hCF0, v); check("R12", "unmapped 0xCF0", v, 32'h0);
        bus_write(12'h960, 32'h0);
        repeat (2 * LAT + 2) @(posedge clk);
        @(negedge clk);
        bus_read(12'h960, v); check("R12", "status write ignored", v, req_sh[0]);
        bus_read(12'h900, v); check("R12", "request untouched", v, req_sh[0]);

        // R3 close, then R4 refuse
        bus_write(12'hCF4, 32'hA5A5_A500);
        bus_read(12'hCF4, v); check("R3", "shut key", v, 32'h0);
        bus_write(12'h904, 32'h0);
        bus_read(12'h904, v); check("R4", "refused after close", v, req_sh[1]);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule